// File: doc/BRIEF.md
# Region-Dependent Bus Wait-State Controller

This block sets the length of every access on a small controller's internal bus. Each access is classified by its address. Low addresses hold the special-function registers. Every other address is internal memory. The block stretches the access to the right number of bus-clock cycles and raises a ready signal in the last of them.

For internal memory, a software-controlled slow-mode bit picks the length: one cycle when the bit is clear and two cycles when it is set. Register-space accesses always take two cycles. The slow-mode bit lives in a mode register. That register can only be written after a separate unlock bit in a guard register has been set, and each successful mode write uses up the unlock.

A requester holds its request, address and write data stable until it sees ready. It may present the next request in the cycle right after.

Top module: `area_wait_ctrl`

## Requirements
- R1: With the slow-mode bit at 0, an access to an address at or above 0x0400 (internal memory) raises rspReady in the same cycle the request is first presented.
- R2: With the slow-mode bit at 1, an internal-memory access raises rspReady in its second cycle, not its first.
- R3: An access to an address from 0x0000 to 0x03FF (register space) raises rspReady in its second cycle, whatever the slow-mode bit holds.
- R4: After reset the slow-mode bit and the unlock bit are 0, a read of the mode register returns 0x00, and rspReady is low while no request is presented.
- R5: A write to the mode register (address 0x0005) while the unlock bit is 0 leaves the slow-mode bit unchanged, and the access still completes in two cycles.
- R6: While the unlock bit is 1, a write to address 0x0005 loads write-data bit 7 into the slow-mode bit. Writing address 0x000A loads write-data bit 1 into the unlock bit. On reads, 0x0005 returns the slow-mode bit at bit 7 and 0x000A returns the unlock bit at bit 1, with all other bits 0. Reads of any other address return 0.
- R7: The unlock bit returns to 0 after each successful mode-register write, so a second write needs a new unlock.
- R8: rspReady is high only in the final cycle of an access. A new request presented in the next cycle starts a new access.
- R9: The access that starts immediately after a completed mode-register write uses the newly written slow-mode value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Access request, held until rspReady |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 16 | Access address |
| reqWdata | input | 8 | Write data |
| rspReady | output | 1 | High in the final cycle of the access |
| rspRdata | output | 8 | Read data, valid while rspReady is high on a read |

## Verification
The hardest case to reach from the ports is the lock path. A mode write only lands when an unlock write came earlier and no other mode write has used it since. The same write must then change the length of the very next memory access. Random traffic reaches this by hitting the two control addresses often and by setting write-data bits 1 and 7 often. Directed sequences cover a locked write, an unlock followed by two mode writes, and a mode write followed back-to-back by a memory access. Every access's cycle count and read value are compared with a model that keeps its own slow-mode and unlock bits.

// File: rtl/awc_pkg.sv
package awc_pkg;
  // Strobes issued by the control to the register datapath
  typedef struct packed {
    logic finish;   // final cycle of the current access
    logic rdEn;     // final cycle of a read
    logic wrMode;   // final cycle of a write to the mode register
    logic wrProt;   // final cycle of a write to the guard register
  } awcStrobe_t;
endpackage

// File: rtl/awc_decode.sv
module awc_decode #(
  parameter int ADDR_W    = 16,
  parameter int SFR_TOP   = 'h400,
  parameter int MODE_ADDR = 'h005,
  parameter int PROT_ADDR = 'h00A
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              isSfr,
  output logic              isMode,
  output logic              isProt
);
  localparam logic [ADDR_W-1:0] SfrTopA  = ADDR_W'(SFR_TOP);
  localparam logic [ADDR_W-1:0] ModeA    = ADDR_W'(MODE_ADDR);
  localparam logic [ADDR_W-1:0] ProtA    = ADDR_W'(PROT_ADDR);

  always_comb begin
    isSfr  = addr < SfrTopA;
    isMode = addr == ModeA;
    isProt = addr == ProtA;
  end
endmodule

// File: rtl/awc_ctrl.sv
module awc_ctrl
  import awc_pkg::*;
#(
  parameter int SFR_CYCLES  = 2,
  parameter int SLOW_CYCLES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqWrite,
  input  logic       isSfr,
  input  logic       isMode,
  input  logic       isProt,
  input  logic       waitBit,
  output awcStrobe_t strobe
);
  localparam int MaxCyc = (SFR_CYCLES > SLOW_CYCLES) ? SFR_CYCLES : SLOW_CYCLES;
  localparam int CntW   = $clog2(MaxCyc + 1);

  logic            busy;
  logic [CntW-1:0] cnt;
  logic [CntW-1:0] needReg;
  logic [CntW-1:0] needNow;
  logic            done;

  // Length is fixed at the first cycle of an access and kept while stretched
  always_comb begin
    if (isSfr)        needNow = CntW'(SFR_CYCLES);
    else if (waitBit) needNow = CntW'(SLOW_CYCLES);
    else              needNow = CntW'(1);
    if (busy) done = (cnt == needReg - CntW'(1));
    else      done = reqValid && (needNow == CntW'(1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      cnt     <= '0;
      needReg <= '0;
    end else if (!busy) begin
      if (reqValid && !done) begin
        busy    <= 1'b1;
        cnt     <= CntW'(1);
        needReg <= needNow;
      end
    end else if (done) begin
      busy <= 1'b0;
    end else begin
      cnt <= cnt + CntW'(1);
    end
  end

  always_comb begin
    strobe.finish = done;
    strobe.rdEn   = done && !reqWrite;
    strobe.wrMode = done && reqWrite && isMode;
    strobe.wrProt = done && reqWrite && isProt;
  end

  AST_SFR_TWO: assert property (@(posedge clk) disable iff (!rstN)
    (SFR_CYCLES > 1) && reqValid && !busy && isSfr |-> !strobe.finish); // R3

  AST_FAST_NOWAIT: assert property (@(posedge clk) disable iff (!rstN)
    strobe.finish && !busy |-> !isSfr && !waitBit); // R2

  AST_READY_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    busy && strobe.finish |=> !busy); // R8
endmodule

// File: rtl/awc_regs.sv
module awc_regs
  import awc_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int WAIT_BIT = 7,
  parameter int PROT_BIT = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  awcStrobe_t        strobe,
  input  logic [DATA_W-1:0] wdata,
  input  logic              isMode,
  input  logic              isProt,
  output logic              waitBit,
  output logic [DATA_W-1:0] rdata
);
  logic protBit;
  logic unusedWdata;

  assign unusedWdata = ^wdata;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      waitBit <= 1'b0;
      protBit <= 1'b0;
    end else if (strobe.wrMode) begin
      if (protBit) begin
        waitBit <= wdata[WAIT_BIT];
        protBit <= 1'b0;
      end
    end else if (strobe.wrProt) begin
      protBit <= wdata[PROT_BIT];
    end
  end

  always_comb begin
    rdata = '0;
    if (strobe.rdEn) begin
      if (isMode) rdata[WAIT_BIT] = waitBit;
      if (isProt) rdata[PROT_BIT] = protBit;
    end
  end

  AST_LOCKED_MODE: assert property (@(posedge clk) disable iff (!rstN)
    !protBit |=> $stable(waitBit)); // R5

  AST_PROT_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrMode && protBit |=> !protBit); // R7
endmodule

// File: rtl/area_wait_ctrl.sv
module area_wait_ctrl
  import awc_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int SFR_TOP     = 'h400,
  parameter int MODE_ADDR   = 'h005,
  parameter int PROT_ADDR   = 'h00A,
  parameter int WAIT_BIT    = 7,
  parameter int PROT_BIT    = 1,
  parameter int SFR_CYCLES  = 2,
  parameter int SLOW_CYCLES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspReady,
  output logic [DATA_W-1:0] rspRdata
);
  awcStrobe_t strobe;
  logic isSfr, isMode, isProt, waitBit;

  awc_decode #(.ADDR_W(ADDR_W), .SFR_TOP(SFR_TOP), .MODE_ADDR(MODE_ADDR),
               .PROT_ADDR(PROT_ADDR)) i_decode (
    .addr(reqAddr), .isSfr(isSfr), .isMode(isMode), .isProt(isProt));

  awc_ctrl #(.SFR_CYCLES(SFR_CYCLES), .SLOW_CYCLES(SLOW_CYCLES)) i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .isSfr(isSfr), .isMode(isMode), .isProt(isProt), .waitBit(waitBit),
    .strobe(strobe));

  awc_regs #(.DATA_W(DATA_W), .WAIT_BIT(WAIT_BIT), .PROT_BIT(PROT_BIT)) i_regs (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wdata(reqWdata),
    .isMode(isMode), .isProt(isProt), .waitBit(waitBit), .rdata(rspRdata));

  assign rspReady = strobe.finish;
endmodule

// File: tb/test_area_wait_ctrl.sv
`timescale 1ns/1ps
module test_area_wait_ctrl;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic reqWrite = 1'b0;
  logic [15:0] reqAddr = '0;
  logic [7:0] reqWdata = '0;
  logic rspReady;
  logic [7:0] rspRdata;

  int errors = 0;
  int checks = 0;
  bit expWait = 1'b0;
  bit expProt = 1'b0;

  always #4 clk = ~clk;

  area_wait_ctrl i_area_wait_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .rspReady(rspReady),
    .rspRdata(rspRdata));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int expCycles(input logic [15:0] a);
    if (a < 16'h0400) return 2;
    return expWait ? 2 : 1;
  endfunction

  function automatic logic [7:0] expRead(input logic [15:0] a);
    if (a == 16'h0005) return {expWait, 7'b0};
    if (a == 16'h000A) return {6'b0, expProt, 1'b0};
    return 8'h00;
  endfunction

  task automatic access(input bit wr, input logic [15:0] a, input logic [7:0] d,
                        output int cyc, output logic [7:0] rd);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d;
    cyc = 1;
    #1;
    while (!rspReady && cyc < 6) begin
      @(negedge clk); #1; cyc++;
    end
    rd = rspRdata;
    @(posedge clk); #1;
    reqValid = 1'b0;
  endtask

  task automatic runOne(input bit wr, input logic [15:0] a, input logic [7:0] d,
                        input string tagIn);
    int cyc;
    logic [7:0] rd;
    int ec;
    logic [7:0] er;
    string tag;
    ec = expCycles(a);
    er = expRead(a);
    if (tagIn != "") tag = tagIn;
    else if (wr && a == 16'h0005) tag = expProt ? "R6" : "R5";
    else if (a < 16'h0400) tag = "R3";
    else tag = expWait ? "R2" : "R1";
    access(wr, a, d, cyc, rd);
    check(cyc == ec, {tag, " cycles"}, cyc, ec);
    if (!wr) check(rd == er, {tag, " R6 rdata"}, rd, er);
    if (wr && a == 16'h0005) begin
      if (expProt) begin expWait = d[7]; expProt = 1'b0; end
    end else if (wr && a == 16'h000A) begin
      expProt = d[1];
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R8 watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    check(rspReady == 1'b0, "R4 idle ready", rspReady, 0);
    runOne(1'b0, 16'h0005, 8'h00, "R4");
    runOne(1'b0, 16'h000A, 8'h00, "R4");
    runOne(1'b0, 16'h1234, 8'h00, "R1");
    runOne(1'b1, 16'h0005, 8'h80, "R5");
    runOne(1'b0, 16'h0005, 8'h00, "R5");
    runOne(1'b0, 16'h8000, 8'h00, "R1");
    runOne(1'b1, 16'h000A, 8'h02, "R6");
    runOne(1'b0, 16'h000A, 8'h00, "R6");
    runOne(1'b1, 16'h0005, 8'hFF, "R6");
    runOne(1'b0, 16'h4000, 8'h00, "R9");
    runOne(1'b0, 16'h000A, 8'h00, "R7");
    runOne(1'b1, 16'h0005, 8'h00, "R7");
    runOne(1'b0, 16'h0005, 8'h00, "R7");
    runOne(1'b0, 16'h03FF, 8'h00, "R3");
    runOne(1'b0, 16'h0400, 8'h00, "R2");
    @(negedge clk); #1;
    check(rspReady == 1'b0, "R8 idle after access", rspReady, 0);
    runOne(1'b1, 16'h000A, 8'h02, "R6");
    runOne(1'b1, 16'h0005, 8'h00, "R6");
    runOne(1'b0, 16'h0400, 8'h00, "R9");
    runOne(1'b0, 16'hFFFF, 8'h00, "R8");
    runOne(1'b0, 16'h0000, 8'h00, "R3");
    for (int i = 0; i < 400; i++) begin
      int sel;
      logic [15:0] a;
      logic [7:0] d;
      sel = int'($urandom_range(0, 5));
      d = 8'($urandom);
      if ($urandom_range(0, 1) == 1) d[1] = 1'b1;
      case (sel)
        0: a = 16'h0005;
        1: a = 16'h000A;
        2: a = 16'($urandom_range(0, 16'h03FF));
        default: a = 16'($urandom_range(16'h0400, 16'hFFFF));
      endcase
      runOne($urandom_range(0, 1) == 1, a, d, "");
      if ($urandom_range(0, 7) == 0) @(negedge clk);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule